// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented virtual address into a physical address. The upper bits of the virtual address pick one entry of a small on-chip segment table. The lower bits form an offset into that segment. Each entry holds a base address, a per-segment size limit, a valid flag, two permission bits and two usage bits (referenced and modified). The physical address is the selected base plus the offset. An access is refused with a fault code when the entry is not valid, when the offset falls outside the segment, or when the permission bits deny the access.

Translation is purely combinational from the request to the result. The usage bits of the selected entry are updated on the next rising clock edge. Software fills the table through a single-cycle configuration write port. Each write loads one whole entry and clears its usage bits. The usage bits of the entry picked by the current address are visible at the outputs, so the manager of the table can sample them.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every entry is invalid with clear usage bits, so any request raises fault code 1 and `hit_ref`/`hit_mod` read 0.
- R2: For a request to a valid entry with offset below its size and a permitted access, `pa_valid` is 1, `fault` is 0, `fault_code` is 0, and `pa` equals base plus offset truncated to PA_BITS. The segment number is `req_vaddr[VA_W-1:OFF_BITS]` and the offset is `req_vaddr[OFF_BITS-1:0]`.
- R3: A request to an entry whose valid flag is clear raises `fault` with `fault_code` 1 (invalid segment).
- R4: A request whose offset is greater than or equal to the entry's own size raises `fault` with `fault_code` 2 (bounds). A size of 0 makes every access to that segment a bounds fault.
- R5: A read to an entry with `perm[0]`=0, or a write to an entry with `perm[1]`=0, raises `fault` with `fault_code` 3 (protection).
- R6: When several fault conditions hold, the code reported is chosen in this order of priority: invalid (1) over bounds (2) over protection (3).
- R7: On any fault `pa` is 0 and `pa_valid` is 0, and the entry's usage bits do not change.
- R8: A successful access sets the entry's referenced bit at the next clock edge. A successful write also sets its modified bit. A successful read leaves the modified bit unchanged.
- R9: A configuration write loads base, size, valid and permission into entry `cfg_idx` at the clock edge and clears that entry's usage bits. If a successful access to the same entry happens in the same cycle, the configuration write wins.
- R10: With `req_valid` low, `fault` and `pa_valid` are 0 and no usage bit changes.
- R11: `hit_ref` and `hit_mod` show the current usage bits of the entry selected by the segment field of `req_vaddr`, whether or not `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write (0 = read) |
| req_vaddr | input | VA_W (15) | Virtual address: segment number above offset |
| pa | output | PA_BITS (16) | Physical address, 0 when not issued |
| pa_valid | output | 1 | Physical address issued |
| fault | output | 1 | Request refused |
| fault_code | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |
| hit_ref | output | 1 | Referenced bit of the addressed entry |
| hit_mod | output | 1 | Modified bit of the addressed entry |
| cfg_we | input | 1 | Load one table entry |
| cfg_idx | input | SEG_BITS (3) | Entry to load |
| cfg_base | input | PA_BITS (16) | Base address to load |
| cfg_size | input | OFF_BITS+1 (13) | Segment size in bytes to load |
| cfg_valid | input | 1 | Valid flag to load |
| cfg_perm | input | 2 | bit0 read allowed, bit1 write allowed |

## Verification
Suppose a stored base or size is corrupted. The next request to that segment then shows a wrong `pa` or a wrong choice between code 2 and a clean result, in the same cycle as the request. Suppose a usage bit is set or cleared wrongly. That shows up one clock later on `hit_ref`/`hit_mod`, once the segment is addressed again. The bench therefore compares every request against a model of the table, including the usage bits, and each fault is tested alone and in combination with the others to expose the priority order.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROT    = 2'd3
  } flt_e;

  // Relocation sum on a wide carrier; callers truncate to their address width.
  function automatic logic [31:0] reloc_sum(input logic [31:0] base, input logic [31:0] off);
    return base + off;
  endfunction

  // Fault priority: invalid, then bounds, then permission.
  function automatic flt_e judge(input logic vld, input logic oob,
                                 input logic rd_ok, input logic wr_ok,
                                 input logic is_wr);
    if (!vld)                 return FLT_INVALID;
    else if (oob)             return FLT_BOUNDS;
    else if (is_wr && !wr_ok) return FLT_PROT;
    else if (!is_wr && !rd_ok) return FLT_PROT;
    else                      return FLT_NONE;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [PA_BITS-1:0]  cfg_base,
  input  logic [OFF_BITS:0]   cfg_size,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_perm,
  input  logic                upd_en,
  input  logic                upd_wr,
  input  logic [SEG_BITS-1:0] sel_idx,
  output logic [PA_BITS-1:0]  sel_base,
  output logic [OFF_BITS:0]   sel_size,
  output logic                sel_vld,
  output logic [1:0]          sel_perm,
  output logic                sel_ref,
  output logic                sel_mod
);
  localparam int ENTRIES = 1 << SEG_BITS;

  logic [PA_BITS-1:0] base_q [ENTRIES];
  logic [OFF_BITS:0]  size_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, ref_q, mod_q;
  logic [1:0]         perm_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    wire load_here = cfg_we && (cfg_idx == SEG_BITS'(e));
    wire use_here  = upd_en && (sel_idx == SEG_BITS'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        size_q[e] <= '0;
        vld_q[e]  <= 1'b0;
        perm_q[e] <= 2'b00;
        ref_q[e]  <= 1'b0;
        mod_q[e]  <= 1'b0;
      end else if (load_here) begin
        base_q[e] <= cfg_base;
        size_q[e] <= cfg_size;
        vld_q[e]  <= cfg_valid;
        perm_q[e] <= cfg_perm;
        ref_q[e]  <= 1'b0;
        mod_q[e]  <= 1'b0;
      end else if (use_here) begin
        ref_q[e] <= 1'b1;
        if (upd_wr) mod_q[e] <= 1'b1;
      end
    end

    // R8
    mod_implies_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_q[e] |-> ref_q[e]);
  end

  assign sel_base = base_q[sel_idx];
  assign sel_size = size_q[sel_idx];
  assign sel_vld  = vld_q[sel_idx];
  assign sel_perm = perm_q[sel_idx];
  assign sel_ref  = ref_q[sel_idx];
  assign sel_mod  = mod_q[sel_idx];

  // R8
  ref_after_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(cfg_we && cfg_idx == sel_idx)) |=> ref_q[$past(sel_idx)]);

  // R8
  mod_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_wr && !(cfg_we && cfg_idx == sel_idx)) |=> mod_q[$past(sel_idx)]);

  // R9
  load_clears_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !ref_q[$past(cfg_idx)] && !mod_q[$past(cfg_idx)]);

endmodule

// File: rtl/seg_check.sv
module seg_check
  import segx_pkg::*;
#(
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [OFF_BITS-1:0] off,
  input  logic [PA_BITS-1:0]  base,
  input  logic [OFF_BITS:0]   size,
  input  logic                vld,
  input  logic [1:0]          perm,
  output logic [PA_BITS-1:0]  pa,
  output logic                pa_valid,
  output logic                fault,
  output logic [1:0]          fault_code,
  output logic                access_ok
);
  logic out_of_bounds;
  flt_e verdict;

  assign out_of_bounds = {1'b0, off} >= size;
  assign verdict   = req_valid ? judge(vld, out_of_bounds, perm[0], perm[1], req_write)
                               : FLT_NONE;
  assign fault     = req_valid && (verdict != FLT_NONE);
  assign access_ok = req_valid && (verdict == FLT_NONE);
  assign pa_valid  = access_ok;
  assign fault_code = verdict;
  assign pa = access_ok ? PA_BITS'(reloc_sum(32'(base), 32'(off))) : '0;

  // R7
  no_pa_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !pa_valid && pa == '0);

  // R4
  issued_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> ({1'b0, off} < size) && vld);

  // R3
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vld) |-> fault && fault_code == 2'd1);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !fault && !pa_valid);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  localparam int VA_W    = SEG_BITS + OFF_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic [PA_BITS-1:0]  pa,
  output logic                pa_valid,
  output logic                fault,
  output logic [1:0]          fault_code,
  output logic                hit_ref,
  output logic                hit_mod,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [PA_BITS-1:0]  cfg_base,
  input  logic [OFF_BITS:0]   cfg_size,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_perm
);
  logic [SEG_BITS-1:0] seg_no;
  logic [OFF_BITS-1:0] seg_off;
  logic [PA_BITS-1:0]  ent_base;
  logic [OFF_BITS:0]   ent_size;
  logic                ent_vld;
  logic [1:0]          ent_perm;
  logic                access_ok;

  assign seg_no  = req_vaddr[VA_W-1:OFF_BITS];
  assign seg_off = req_vaddr[OFF_BITS-1:0];

  seg_table #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
    .upd_en(access_ok), .upd_wr(req_write), .sel_idx(seg_no),
    .sel_base(ent_base), .sel_size(ent_size), .sel_vld(ent_vld), .sel_perm(ent_perm),
    .sel_ref(hit_ref), .sel_mod(hit_mod)
  );

  seg_check #(.OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_check (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .off(seg_off),
    .base(ent_base), .size(ent_size), .vld(ent_vld), .perm(ent_perm),
    .pa(pa), .pa_valid(pa_valid), .fault(fault), .fault_code(fault_code),
    .access_ok(access_ok)
  );

  // R7
  fault_keeps_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !cfg_we && $past(rst_n)) |=> (hit_ref == $past(hit_ref)) || (seg_no != $past(seg_no)));

endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  localparam int SB = 3, OB = 12, PB = 16, VW = SB + OB, NE = 1 << SB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [VW-1:0] req_vaddr = '0;
  logic [PB-1:0] pa;
  logic pa_valid, fault, hit_ref, hit_mod;
  logic [1:0] fault_code;
  logic cfg_we = 0, cfg_valid = 0;
  logic [SB-1:0] cfg_idx = '0;
  logic [PB-1:0] cfg_base = '0;
  logic [OB:0] cfg_size = '0;
  logic [1:0] cfg_perm = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [PB-1:0] m_base [NE];
  logic [OB:0]   m_size [NE];
  logic          m_vld [NE], m_ref [NE], m_mod [NE];
  logic [1:0]    m_perm [NE];

  seg_xlate_unit i_seg_xlate_unit (.*);

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int s, input int off, input bit wr);
    if (!m_vld[s]) return 1;
    if (off >= int'(m_size[s])) return 2;
    if (wr && !m_perm[s][1]) return 3;
    if (!wr && !m_perm[s][0]) return 3;
    return 0;
  endfunction

  // One cycle: optional config write and optional request, checked before the edge.
  task automatic cycle(input bit rv, input bit wr, input int s, input int off,
                       input bit cw, input int ci, input int cb, input int cs,
                       input bit cv, input int cp, input string tag);
    int code; logic [PB-1:0] epa;
    @(negedge clk);
    req_valid = rv; req_write = wr; req_vaddr = {SB'(s), OB'(off)};
    cfg_we = cw; cfg_idx = SB'(ci); cfg_base = PB'(cb); cfg_size = (OB+1)'(cs);
    cfg_valid = cv; cfg_perm = 2'(cp);
    #1;
    code = rv ? exp_code(s, off, wr) : 0;
    epa = (rv && code == 0) ? PB'(m_base[s] + PB'(off)) : '0;
    chk(fault_code == 2'(code), {tag, " R3/R4/R5/R6 code"}, fault_code, code);
    chk(fault == (code != 0), {tag, " R7 fault"}, fault, code != 0);
    chk(pa_valid == (rv && code == 0), {tag, " R2/R10 pa_valid"}, pa_valid, rv && code == 0);
    chk(pa == epa, {tag, " R2 pa"}, pa, epa);
    chk(hit_ref == m_ref[s] && hit_mod == m_mod[s], {tag, " R11 usage"},
        {hit_ref, hit_mod}, {m_ref[s], m_mod[s]});
    @(posedge clk);
    if (rv && code == 0) begin
      m_ref[s] = 1; if (wr) m_mod[s] = 1;
    end
    if (cw) begin
      m_base[ci] = PB'(cb); m_size[ci] = (OB+1)'(cs); m_vld[ci] = cv;
      m_perm[ci] = 2'(cp); m_ref[ci] = 0; m_mod[ci] = 0;
    end
    #1;
    req_valid = 0; cfg_we = 0;
  endtask

  task automatic load(input int ci, input int cb, input int cs, input bit cv, input int cp);
    cycle(0, 0, 0, 0, 1, ci, cb, cs, cv, cp, "cfg");
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_vld[i] = 0; m_perm[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state, every segment invalid
    for (int s = 0; s < NE; s++) cycle(1, s[0], s, 5, 0, 0, 0, 0, 0, 0, "R1 reset");
    // R2 plain read and write, wrap of the sum
    load(2, 16'h1000, 256, 1, 3);
    cycle(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R2 read base");
    cycle(1, 1, 2, 255, 0, 0, 0, 0, 0, 0, "R8 write last byte");
    load(5, 16'hFF00, 4096, 1, 3);
    cycle(1, 0, 5, 4095, 0, 0, 0, 0, 0, 0, "R2 wrap");
    // R4 bounds: offset == size, size 0
    cycle(1, 0, 2, 256, 0, 0, 0, 0, 0, 0, "R4 at size");
    load(3, 16'h2000, 0, 1, 3);
    cycle(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, "R4 size zero");
    // R5 protection: read-only and write-only
    load(4, 16'h3000, 64, 1, 1);
    cycle(1, 1, 4, 3, 0, 0, 0, 0, 0, 0, "R5 write to read-only");
    cycle(1, 0, 4, 3, 0, 0, 0, 0, 0, 0, "R8 read leaves mod");
    load(6, 16'h4000, 64, 1, 2);
    cycle(1, 0, 6, 3, 0, 0, 0, 0, 0, 0, "R5 read of write-only");
    // R6 priority: invalid over bounds, bounds over protection
    load(7, 16'h5000, 16, 0, 0);
    cycle(1, 1, 7, 100, 0, 0, 0, 0, 0, 0, "R6 invalid first");
    cycle(1, 1, 4, 64, 0, 0, 0, 0, 0, 0, "R6 bounds over prot");
    // R7 fault leaves usage clear
    cycle(1, 1, 6, 3, 0, 0, 0, 0, 0, 0, "R7 after fault");
    // R10 idle request makes no update
    load(1, 16'h0100, 32, 1, 3);
    cycle(0, 1, 1, 4, 0, 0, 0, 0, 0, 0, "R10 idle");
    cycle(1, 0, 1, 4, 0, 0, 0, 0, 0, 0, "R10 no ref after idle");
    // R9 config wins over same-cycle use
    cycle(1, 1, 1, 4, 1, 1, 16'h0200, 32, 1, 3, "R9 collide");
    cycle(1, 0, 1, 4, 0, 0, 0, 0, 0, 0, "R9 cleared after collide");
    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int s, off, pick;
      s = $urandom_range(NE - 1);
      pick = $urandom_range(9);
      if (pick < 2)
        load(s, $urandom_range(16'hFFFF), $urandom_range(4096), $urandom_range(7) != 0,
             $urandom_range(3));
      else begin
        if (pick < 5) off = int'(m_size[s]) - 1 + $urandom_range(1);
        else off = $urandom_range(4095);
        if (off < 0) off = 0;
        if (off > 4095) off = 4095;
        cycle($urandom_range(5) != 0, $urandom_range(1), s, off,
              pick == 9, $urandom_range(NE - 1), $urandom_range(16'hFFFF),
              $urandom_range(4096), 1, 3, "rand R2-mix R8 R9");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule